// File: doc/BRIEF.md
# DMA Channel Request Arbiter with Bus-Hold Handshake

The block sits between four peripheral DMA request lines and the processor's bus-hold interface. A small mode register holds one enable bit per channel, and requests from disabled channels are masked out. When an enabled request is pending, the arbiter raises a hold request toward the processor. It waits for the processor to return hold acknowledge, which means the system bus has been released. It then latches a winning channel by fixed priority and drives that channel's acknowledge line.

The grant stays with that channel for as long as its request stays asserted. Service ends when the channel drops its request or its terminal-count pulse arrives. The arbiter then lowers hold request for one clock and returns to idle, where it can pick up the next request.

The controller has four states. `ST_IDLE` keeps hold request low. `ST_WAIT_BUS` raises hold request and waits for acknowledge. `ST_SERVE` keeps hold request high and drives the latched grant. `ST_RELEASE` drops hold request for one clock. The transitions are:

- IDLE→WAIT_BUS when any enabled request is present.
- WAIT_BUS→IDLE when every enabled request is withdrawn.
- WAIT_BUS→SERVE when hold acknowledge is high and an enabled request is present; the grant is latched on this transition.
- SERVE→RELEASE when the granted channel's enabled request is gone, or when that channel's terminal-count pulse arrives.
- RELEASE→IDLE unconditionally.

Top module: `dma_req_arbiter`

## Requirements
- R1: A synchronous active-high reset clears hold request, clears all acknowledges and clears the enable field, so that no channel is enabled; after reset, requests on all four channels leave hold request low.
- R2: A write with `mode_we` high loads `mode_wdata` into the enable field at the next clock edge. Bit i enables channel i. A request on a channel whose bit is 0 is ignored, and hold request stays low.
- R3: An enabled request seen in idle raises `hold_req` at the next clock edge. If every enabled request is withdrawn before `hold_ack`, `hold_req` falls at the next clock edge.
- R4: No acknowledge is active while `hold_ack` is low, including during service; acknowledge follows `hold_ack` in the same cycle.
- R5: When `hold_ack` is high while hold request is raised, the winning channel's acknowledge becomes active at the next clock edge. Acknowledge is one-hot, with bit i meaning channel i.
- R6: Fixed priority applies among the enabled requests: channel 0 is highest and channel 3 is lowest.
- R7: The latched grant does not change while the granted channel's enabled request stays asserted, even if requests of higher priority appear.
- R8: `hold_req` and the acknowledge fall one clock after the granted channel's request deasserts or its `tc` bit is seen high. A `tc` bit for any other channel has no effect.
- R9: After a release, `hold_req` stays low for one further idle clock before a still-pending request raises it again.
- R10: At most one acknowledge output is active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Write strobe for the enable field |
| mode_wdata | input | NCH | New enable bits, bit i for channel i |
| dreq | input | NCH | Peripheral request lines |
| tc | input | NCH | Terminal-count pulse per channel |
| hold_ack | input | 1 | Bus released by the processor |
| hold_req | output | 1 | Bus request to the processor |
| dack | output | NCH | One-hot channel acknowledge |

## Verification
A wrong state or a stale grant register shows at the ports within one clock. A wrong state gives a `hold_req` level that does not fit the request history. A stale grant gives an acknowledge that moves while its request is held, or that outlives a drop or a terminal count. The bench sweeps every enable pattern against every non-empty request pattern. For each pair it predicts the winner arithmetically and checks hold request, acknowledge, grant stability, a foreign terminal-count pulse, the release and the re-arm cycle at the exact cycle each should change. A masking fault shows as a hold request raised for a disabled channel on the first clock after the request.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_BUS = 2'd1,
        ST_SERVE    = 2'd2,
        ST_RELEASE  = 2'd3
    } arb_state_t;
endpackage

// File: rtl/dma_mode_reg.sv
module dma_mode_reg #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [NCH-1:0] wdata,
    output logic [NCH-1:0] ch_en
);
    always_ff @(posedge clk) begin
        if (rst)     ch_en <= '0;
        else if (we) ch_en <= wdata;
    end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] req,
    output logic [NCH-1:0] pick
);
    // lowest index wins
    assign pick[0] = req[0];
    for (genvar i = 1; i < NCH; i++) begin : g_pick
        assign pick[i] = req[i] & ~(|req[i-1:0]);
    end
endmodule

// File: rtl/dma_hold_fsm.sv
module dma_hold_fsm
    import dma_arb_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] live_req,
    input  logic [NCH-1:0] pick,
    input  logic [NCH-1:0] tc,
    input  logic           hold_ack,
    output logic           hold_req,
    output logic [NCH-1:0] dack
);
    arb_state_t     state_q, state_d;
    logic [NCH-1:0] grant_q, grant_d;
    logic           any_req, grant_live, grant_tc;

    assign any_req    = |live_req;
    assign grant_live = |(grant_q & live_req);
    assign grant_tc   = |(grant_q & tc);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            grant_q <= '0;
        end else begin
            state_q <= state_d;
            grant_q <= grant_d;
        end
    end

    always_comb begin
        state_d = state_q;
        grant_d = grant_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any_req) state_d = ST_WAIT_BUS;
            end
            ST_WAIT_BUS: begin
                if (!any_req) begin
                    state_d = ST_IDLE;
                end else if (hold_ack) begin
                    state_d = ST_SERVE;
                    grant_d = pick;
                end
            end
            ST_SERVE: begin
                if (!grant_live || grant_tc) begin
                    state_d = ST_RELEASE;
                    grant_d = '0;
                end
            end
            ST_RELEASE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
                grant_d = '0;
            end
        endcase
    end

    always_comb begin
        hold_req = 1'b0;
        dack     = '0;
        unique case (state_q)
            ST_IDLE:     hold_req = 1'b0;
            ST_WAIT_BUS: hold_req = 1'b1;
            ST_SERVE: begin
                hold_req = 1'b1;
                dack     = hold_ack ? grant_q : '0;
            end
            ST_RELEASE:  hold_req = 1'b0;
            default:     hold_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           mode_we,
    input  logic [NCH-1:0] mode_wdata,
    input  logic [NCH-1:0] dreq,
    input  logic [NCH-1:0] tc,
    input  logic           hold_ack,
    output logic           hold_req,
    output logic [NCH-1:0] dack
);
    logic [NCH-1:0] ch_en;
    logic [NCH-1:0] live_req;
    logic [NCH-1:0] pick;

    dma_mode_reg #(.NCH(NCH)) u_mode (
        .clk(clk), .rst(rst), .we(mode_we), .wdata(mode_wdata), .ch_en(ch_en)
    );

    assign live_req = dreq & ch_en;

    dma_prio_pick #(.NCH(NCH)) u_pick (
        .req(live_req), .pick(pick)
    );

    dma_hold_fsm #(.NCH(NCH)) u_fsm (
        .clk(clk), .rst(rst), .live_req(live_req), .pick(pick), .tc(tc),
        .hold_ack(hold_ack), .hold_req(hold_req), .dack(dack)
    );
endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] ch_en,
    input logic [NCH-1:0] dreq,
    input logic [NCH-1:0] tc,
    input logic           hold_ack,
    input logic           hold_req,
    input logic [NCH-1:0] dack
);
    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!hold_req && dack == '0)); // R1
    AST_MASKED_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!hold_req && (dreq & ch_en) == '0) |=> !hold_req); // R2
    AST_NO_ACK_WO_HOLD: assert property (@(posedge clk) disable iff (rst)
        !hold_ack |-> dack == '0); // R4
    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        (|dack) |-> hold_req); // R5
    AST_GRANT_STABLE: assert property (@(posedge clk) disable iff (rst)
        ((|dack) && (|$past(dack))) |-> dack == $past(dack)); // R7
    AST_END_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ((|dack) && (((dack & dreq & ch_en) == '0) || ((dack & tc) != '0))) |=> !hold_req); // R8
    AST_ONE_ACK: assert property (@(posedge clk) disable iff (rst) $onehot0(dack)); // R10
endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst(rst), .ch_en(ch_en), .dreq(dreq), .tc(tc),
    .hold_ack(hold_ack), .hold_req(hold_req), .dack(dack)
);

// File: tb/tb_dma_req_arbiter.sv
`timescale 1ns/1ps
module tb_dma_req_arbiter;
    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           mode_we = 1'b0;
    logic [NCH-1:0] mode_wdata = '0;
    logic [NCH-1:0] dreq = '0;
    logic [NCH-1:0] tc = '0;
    logic           hold_ack = 1'b0;
    logic           hold_req;
    logic [NCH-1:0] dack;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    dma_req_arbiter #(.NCH(NCH)) dut (
        .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .dreq(dreq), .tc(tc), .hold_ack(hold_ack), .hold_req(hold_req), .dack(dack)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [NCH-1:0] lowest(input logic [NCH-1:0] v);
        for (int i = 0; i < NCH; i++)
            if (v[i]) return NCH'(1 << i);
        return '0;
    endfunction

    task automatic write_mode(input logic [NCH-1:0] v);
        mode_we = 1'b1; mode_wdata = v;
        tick();
        mode_we = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        check("R1 hold_req after reset", int'(hold_req), 0);
        check("R1 dack after reset", int'(dack), 0);
        dreq = 4'hF;
        tick(); tick();
        check("R1 enables cleared", int'(hold_req), 0);
        dreq = '0;

        // R3 withdrawal before acknowledge
        write_mode(4'hF);
        dreq = 4'b0010;
        tick();
        check("R3 hold_req rises", int'(hold_req), 1);
        dreq = '0;
        tick();
        check("R3 hold_req falls on withdraw", int'(hold_req), 0);

        // R4 acknowledge follows hold_ack during service
        dreq = 4'b0001;
        tick();
        hold_ack = 1'b1;
        tick();
        check("R5 ack ch0", int'(dack), 1);
        hold_ack = 1'b0;
        #1 check("R4 ack off with hold_ack low", int'(dack), 0);
        check("R4 hold_req kept", int'(hold_req), 1);
        hold_ack = 1'b1;
        #1 check("R4 ack back", int'(dack), 1);
        dreq = '0;
        tick();
        check("R8 release on drop", int'(hold_req), 0);
        hold_ack = 1'b0;
        tick(); tick();

        // R2 R5 R6 R7 R8 R9 sweep
        for (int en = 0; en < 16; en++) begin
            for (int rq = 1; rq < 16; rq++) begin
                logic [NCH-1:0] m, w, other;
                write_mode(NCH'(en));
                m = NCH'(rq) & NCH'(en);
                dreq = NCH'(rq);
                tick();
                if (m == '0) begin
                    check("R2 disabled ignored", int'(hold_req), 0);
                    tick();
                    check("R2 disabled still ignored", int'(hold_req), 0);
                    dreq = '0;
                    continue;
                end
                check("R3 hold_req raised", int'(hold_req), 1);
                check("R4 no ack before hold_ack", int'(dack), 0);
                w = lowest(m);
                hold_ack = 1'b1;
                tick();
                check("R6 priority winner", int'(dack), int'(w));
                dreq = 4'hF;
                tick();
                check("R7 grant held", int'(dack), int'(w));
                other = {w[NCH-2:0], w[NCH-1]};
                tc = other;
                tick();
                tc = '0;
                check("R8 foreign tc ignored", int'(dack), int'(w));
                check("R8 foreign tc hold_req", int'(hold_req), 1);
                if (((en + rq) % 2) == 1) begin
                    tc = w;
                    tick();
                    tc = '0;
                    check("R8 tc release hold_req", int'(hold_req), 0);
                    check("R8 tc release dack", int'(dack), 0);
                    tick();
                    check("R9 idle gap", int'(hold_req), 0);
                    tick();
                    check("R9 re-arm", int'(hold_req), 1);
                    dreq = '0; hold_ack = 1'b0;
                    tick(); tick();
                end else begin
                    dreq = '0;
                    tick();
                    check("R8 drop release hold_req", int'(hold_req), 0);
                    check("R8 drop release dack", int'(dack), 0);
                    hold_ack = 1'b0;
                    tick();
                end
            end
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule